// File: doc/BRIEF.md
# Dual-Rail Completion-Detecting Adder

This block adds two unsigned operands with a ripple carry chain in which every carry position is held on two rails. With two rails, a position can be in an empty state that is distinct from both logical values. The adder can therefore tell by itself when its carry chain has finished, instead of waiting a fixed number of cycles sized for the longest possible ripple.

A start strobe begins a computation. It captures the operands and forces every carry pair into the empty (spacer) state for one cycle, much like a precharge phase. Evaluation then begins. In each clock cycle a carry position can settle in one of two ways. If both operand bits agree, it settles at once, because the pair generates or kills the carry. Otherwise it settles one cycle after its lower neighbour, by copying that neighbour's carry. The completion output rises as soon as every position holds a code. The number of cycles a computation takes therefore depends on the operands, and is set by the longest run of propagating bit positions. The result and the completion output then stay unchanged until the next start that is accepted.

Top module: `dr_completion_adder`

## Requirements
- R1: After synchronous reset, `done` is low, `sum` is all zeros and `illegal` is low.
- R2: A start that is accepted captures `op_a` and `op_b` and sets every carry pair to empty (rails 00). `done` is low in the cycle after the accepted start.
- R3: Each carry pair is coded with the bit order {hi, lo}: 00 is empty, 01 is logical 0, 10 is logical 1, and 11 is illegal. `illegal` is high exactly when some pair holds 11, so it never rises in correct operation.
- R4: A position whose two operand bits are equal takes its code (10 if both are 1, 01 if both are 0) on the first evaluate step, whatever the code of its incoming carry.
- R5: Position 0 takes a constant carry-in of logical 0 and settles on the first evaluate step. Any other position whose operand bits differ copies its lower neighbour's code one evaluate step after that neighbour became valid. `done` rises T+1 clock edges after the edge on which start was accepted, where T is the largest settle step over all positions.
- R6: `done` is the AND over all positions of the OR of each pair's two rails, and it is high only in the evaluate phase. Once high, it stays high until the next accepted start.
- R7: `sum` is WIDTH+1 bits wide and equals `op_a + op_b`, with the carry out in the MSB, while `done` is high. It is all zeros while `done` is low.
- R8: A start is accepted only when the block is idle or `done` is high. A start during the spacer phase, or during evaluation while `done` is low, is ignored: it changes neither the captured operands, the result nor the completion time.
- R9: Once a carry pair holds a valid code, it keeps that code until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation (sampled on the rising clock edge) |
| op_a | input | WIDTH | First operand, captured when start is accepted |
| op_b | input | WIDTH | Second operand, captured when start is accepted |
| sum | output | WIDTH+1 | Result with the carry out in the MSB; zero while done is low |
| done | output | 1 | Every carry pair holds a valid code |
| illegal | output | 1 | Some carry pair holds the illegal code 11 |

## Verification
The assertions assume that `op_a` and `op_b` only matter in the cycle in which a start is accepted. They also assume that a start pulse may arrive in any phase, so the property on ignored starts is written against the block's busy state and not against the bench's timing. The stimulus drives every pair of operands for a 4-bit adder, back to back, and computes each expected result and latency from the operands alone. It also deliberately sends starts, with other operands, during the spacer cycle and during evaluation, to exercise the rule that such starts are ignored.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } dr_pair_t;

    localparam dr_pair_t DR_EMPTY = 2'b00;
    localparam dr_pair_t DR_ZERO  = 2'b01;
    localparam dr_pair_t DR_ONE   = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SPACER = 2'd1,
        PH_EVAL   = 2'd2
    } phase_t;

    function automatic logic dr_filled(dr_pair_t p);
        return p.hi | p.lo;
    endfunction

    function automatic logic dr_bad(dr_pair_t p);
        return p.hi & p.lo;
    endfunction

    function automatic dr_pair_t dr_encode(logic v);
        return v ? DR_ONE : DR_ZERO;
    endfunction

endpackage

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
    import dr_adder_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     eval,
    input  logic     a_bit,
    input  logic     b_bit,
    input  dr_pair_t cin,
    output dr_pair_t cout
);

    dr_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= DR_EMPTY;
        end else if (clear) begin
            pair_q <= DR_EMPTY;
        end else if (eval && !dr_filled(pair_q)) begin
            if (a_bit == b_bit) begin
                pair_q <= dr_encode(a_bit);
            end else if (dr_filled(cin)) begin
                pair_q <= cin;
            end
        end
    end

    assign cout = pair_q;

endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  dr_pair_t [WIDTH-1:0] pairs,
    output logic                 all_filled,
    output logic                 any_bad
);

    always_comb begin
        all_filled = 1'b1;
        any_bad    = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            all_filled = all_filled & dr_filled(pairs[i]);
            any_bad    = any_bad | dr_bad(pairs[i]);
        end
    end

endmodule

// File: rtl/dr_phase_ctrl.sv
module dr_phase_ctrl
    import dr_adder_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   all_filled,
    output phase_t phase,
    output logic   accept,
    output logic   eval,
    output logic   busy
);

    phase_t phase_q;

    assign accept = start && (phase_q == PH_IDLE || (phase_q == PH_EVAL && all_filled));
    assign eval   = (phase_q == PH_EVAL);
    assign busy   = (phase_q != PH_IDLE);
    assign phase  = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (accept) begin
            phase_q <= PH_SPACER;
        end else if (phase_q == PH_SPACER) begin
            phase_q <= PH_EVAL;
        end
    end

endmodule

// File: rtl/dr_completion_adder.sv
module dr_completion_adder
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum,
    output logic             done,
    output logic             illegal
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0]     opa_q;
    logic [WIDTH-1:0]     opb_q;
    dr_pair_t [WIDTH:0]   chain;
    dr_pair_t [WIDTH-1:0] carry_q;
    logic [SUM_W-1:0]     sum_raw;
    logic                 all_filled;
    logic                 any_bad;
    logic                 accept;
    logic                 eval;
    logic                 busy;
    phase_t               phase;

    dr_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .all_filled (all_filled),
        .phase      (phase),
        .accept     (accept),
        .eval       (eval),
        .busy       (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (accept) begin
            opa_q <= op_a;
            opb_q <= op_b;
        end
    end

    assign chain[0] = DR_ZERO;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        dr_carry_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .clear (accept),
            .eval  (eval),
            .a_bit (opa_q[i]),
            .b_bit (opb_q[i]),
            .cin   (chain[i]),
            .cout  (chain[i+1])
        );
        assign sum_raw[i] = opa_q[i] ^ opb_q[i] ^ chain[i].hi;
    end

    assign sum_raw[WIDTH] = chain[WIDTH].hi;
    assign carry_q        = chain[WIDTH:1];

    dr_done_detect #(.WIDTH(WIDTH)) u_detect (
        .pairs      (carry_q),
        .all_filled (all_filled),
        .any_bad    (any_bad)
    );

    assign done    = eval && all_filled;
    assign sum     = done ? sum_raw : '0;
    assign illegal = any_bad;

endmodule

// File: rtl/dr_completion_adder_chk.sv
module dr_completion_adder_chk
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic [WIDTH:0]       sum,
    input logic                 illegal,
    input logic                 busy,
    input logic                 clear,
    input logic [WIDTH-1:0]     opa,
    input logic [WIDTH-1:0]     opb,
    input dr_pair_t [WIDTH-1:0] carry
);

    a_r2_start_drops_done: assert property (@(posedge clk) disable iff (rst)
        (start && done) |=> !done);

    a_r2_spacer_empty: assert property (@(posedge clk) disable iff (rst)
        clear |=> (carry == '0));

    a_r3_no_illegal: assert property (@(posedge clk) disable iff (rst)
        !illegal);

    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r7_sum_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |-> (sum == '0));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !done) |=> ($stable(opa) && $stable(opb)));

    for (genvar i = 0; i < WIDTH; i++) begin : g_mono
        a_r9_hold_valid: assert property (@(posedge clk) disable iff (rst)
            (dr_filled(carry[i]) && !clear) |=> (carry[i] == $past(carry[i])));
    end

endmodule

bind dr_completion_adder dr_completion_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .sum     (sum),
    .illegal (illegal),
    .busy    (busy),
    .clear   (accept),
    .opa     (opa_q),
    .opb     (opb_q),
    .carry   (carry_q)
);

// File: tb/test_dr_completion_adder.sv
module test_dr_completion_adder;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W:0]   sum;
    logic         done;
    logic         illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dr_completion_adder #(.WIDTH(W)) i_dr_completion_adder (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (a_in),
        .op_b    (b_in),
        .sum     (sum),
        .done    (done),
        .illegal (illegal)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_edges(input logic [W-1:0] x, input logic [W-1:0] y);
        int tprev = 0;
        int mx = 0;
        for (int i = 0; i < W; i++) begin
            int t;
            if (x[i] == y[i] || i == 0) t = 1;
            else t = tprev + 1;
            if (t > mx) mx = t;
            tprev = t;
        end
        return mx + 1;
    endfunction

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit inj, input string tag);
        int n = 0;
        bit got = 0;
        int exp_sum = int'(x) + int'(y);
        @(negedge clk);
        a_in = x; b_in = y; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
        check(!done && sum == '0, "R2 done low after start", int'(done), 0);
        while (!got && n < 4 * W) begin
            if (inj && n < 2) begin
                start = 1'b1; a_in = ~x; b_in = ~y;
            end
            @(posedge clk);
            n++;
            #1 start = 1'b0;
            @(negedge clk);
            if (done) got = 1;
        end
        check(n == exp_edges(x, y), {tag, " latency"}, n, exp_edges(x, y));
        check(int'(sum) == exp_sum, {tag, " R7 sum"}, int'(sum), exp_sum);
        check(!illegal, "R3 no illegal code", int'(illegal), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!done && sum == '0 && !illegal, "R1 reset state", int'(sum), 0);

        run_op(4'b1010, 4'b1010, 1'b0, "R4 all generate/kill");
        run_op(4'b1111, 4'b0001, 1'b0, "R5 long ripple");

        run_op(4'b0111, 4'b0001, 1'b1, "R8 ignored starts");

        held = sum;
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R6 done holds", int'(done), 1);
        check(sum == held, "R9 result stable", int'(sum), int'(held));

        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_op(W'(i), W'(j), 1'b0, "R5 sweep");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule